// File: doc/BRIEF.md
# Compare Match Output Unit

This block is one compare channel of a timer. It watches the shared timer count and raises a one-cycle equality pulse when the count first reaches the channel's compare value. It combines that pulse with the period-match pulse from the timer's channel 0 to drive an output pin. The waveform comes from a 3-bit mode, which lets a single channel produce set, reset, toggle and PWM shapes in up, continuous and up/down counting.

Each compare match also sets a sticky interrupt flag and samples the level of the capture input into a latched bit. In mode 0 the output pin is driven straight from a software bit. The counter and its counting-direction logic are outside this block. The channel only sees the count value and the period-match pulse.

Top module: `cmp_out_unit`

## Requirements
- R1: While rst_ni is low, flag_o and scci_o are 0 and the registered output is 0, so out_o reads 0 for any mode other than 0.
- R2: equ_o is 1, combinationally, in a cycle where cnt_i equals cmp_val_i and the value registered at the previous clock edge was not a match. A count held on the compare value gives one pulse only, and equ_o is never high in two consecutive cycles.
- R3: At a clock edge with equ_o high, flag_o becomes 1. It stays 1 until an edge where flag_clr_i is 1 and equ_o is 0. If a clear and a match arrive at the same edge, the flag is set.
- R4: At a clock edge with equ_o high, scci_o takes the value of cci_i. At every other edge scci_o holds its value.
- R5: With mode_i = 0, out_o equals sw_out_i at once, without waiting for a clock edge.
- R6: The single-event modes act at the clock edge after equ_o and ignore equ0_i. Mode 1 sets out_o to 1, mode 4 toggles out_o, and mode 5 resets out_o to 0.
- R7: The modes that reset on the period match act as follows. Mode 2 toggles out_o on equ_o, and mode 3 sets out_o on equ_o. In both modes an edge with equ0_i high drives out_o to 0.
- R8: The modes that set on the period match act as follows. Mode 6 toggles out_o on equ_o, and mode 7 resets out_o on equ_o. In both modes an edge with equ0_i high drives out_o to 1.
- R9: In modes 2, 3, 6 and 7, if equ_o and equ0_i are both high at the same edge, only the equ0_i action applies. This covers channel 0, where both events are the same pulse.
- R10: Once the count has moved off the compare value, returning to it gives a new equ_o pulse. This makes the channel match in both directions of up/down counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Current timer count |
| cmp_val_i | input | CNT_W | Compare value of this channel |
| equ0_i | input | 1 | Period-match pulse from channel 0 |
| mode_i | input | 3 | Output mode, 0 to 7 |
| sw_out_i | input | 1 | Software output level used in mode 0 |
| cci_i | input | 1 | Capture input level |
| flag_clr_i | input | 1 | Clear strobe for the interrupt flag |
| out_o | output | 1 | Output waveform |
| equ_o | output | 1 | Equality pulse |
| flag_o | output | 1 | Sticky interrupt flag |
| scci_o | output | 1 | Capture input level latched on a match |

## Verification
The block has two timing classes of result.
- **Same cycle:** equ_o and, in mode 0, out_o are combinational. The bench checks them one nanosecond after the inputs change, within the same clock cycle.
- **Next edge:** flag_o, scci_o and the registered output change at the first rising edge after the stimulus. The bench drives every vector on the falling edge and checks these results at the following falling edge, after exactly one rising edge has passed.

Vectors that hold the count on the compare value, or that step it away and back, test the first-reach rule. Vectors with simultaneous matches test the priority rule.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
  typedef enum logic [2:0] {
    OM_SW      = 3'd0,
    OM_SET     = 3'd1,
    OM_TOG_RST = 3'd2,
    OM_SET_RST = 3'd3,
    OM_TOG     = 3'd4,
    OM_RST     = 3'd5,
    OM_TOG_SET = 3'd6,
    OM_RST_SET = 3'd7
  } out_mode_e;
endpackage

// File: rtl/cmp_match.sv
module cmp_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             equ_o
);
  logic hit, hit_q;

  assign hit   = (cnt_i == cmp_i);
  assign equ_o = hit & ~hit_q;

  // remembers last cycle's match so a held count does not retrigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= hit;
  end

  p_equ_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    equ_o |=> !equ_o);

  p_equ_rearm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit) |=> (hit == equ_o));
endmodule

// File: rtl/cmp_event_latch.sv
module cmp_event_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic equ_i,
  input  logic cci_i,
  input  logic clr_i,
  output logic flag_o,
  output logic scci_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      scci_o <= 1'b0;
    end else begin
      // a match in the same cycle as a clear keeps the flag
      if (equ_i)      flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
      if (equ_i)      scci_o <= cci_i;
    end
  end

  p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    equ_i |=> flag_o);

  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  p_scci_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    equ_i |=> (scci_o == $past(cci_i)));

  p_scci_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !equ_i |=> $stable(scci_o));
endmodule

// File: rtl/cmp_out_gen.sv
module cmp_out_gen
  import cmp_out_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  out_mode_e mode_i,
  input  logic      equ_i,
  input  logic      equ0_i,
  input  logic      sw_i,
  output logic      out_q_o
);
  logic out_d;

  always_comb begin
    out_d = out_q_o;
    unique case (mode_i)
      OM_SW:      out_d = sw_i;
      OM_SET:     if (equ_i) out_d = 1'b1;
      OM_TOG:     if (equ_i) out_d = ~out_q_o;
      OM_RST:     if (equ_i) out_d = 1'b0;
      OM_TOG_RST: if (equ0_i) out_d = 1'b0; else if (equ_i) out_d = ~out_q_o;
      OM_SET_RST: if (equ0_i) out_d = 1'b0; else if (equ_i) out_d = 1'b1;
      OM_TOG_SET: if (equ0_i) out_d = 1'b1; else if (equ_i) out_d = ~out_q_o;
      OM_RST_SET: if (equ0_i) out_d = 1'b1; else if (equ_i) out_d = 1'b0;
      default:    out_d = out_q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q_o <= 1'b0;
    else         out_q_o <= out_d;
  end

  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_SET && equ_i) |=> out_q_o);

  p_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_RST && equ_i) |=> !out_q_o);

  p_tog_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OM_TOG && equ_i) |=> (out_q_o != $past(out_q_o)));

  p_period_rst_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == OM_TOG_RST || mode_i == OM_SET_RST) && equ0_i) |=> !out_q_o);

  p_period_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == OM_TOG_SET || mode_i == OM_RST_SET) && equ0_i) |=> out_q_o);
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmp_out_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             equ0_i,
  input  logic [2:0]       mode_i,
  input  logic             sw_out_i,
  input  logic             cci_i,
  input  logic             flag_clr_i,
  output logic             out_o,
  output logic             equ_o,
  output logic             flag_o,
  output logic             scci_o
);
  out_mode_e mode;
  logic      out_q;

  assign mode = out_mode_e'(mode_i);

  cmp_match #(.CNT_W(CNT_W)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_i),
    .cmp_i  (cmp_val_i),
    .equ_o  (equ_o)
  );

  cmp_event_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .equ_i  (equ_o),
    .cci_i  (cci_i),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o),
    .scci_o (scci_o)
  );

  cmp_out_gen u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .equ_i   (equ_o),
    .equ0_i  (equ0_i),
    .sw_i    (sw_out_i),
    .out_q_o (out_q)
  );

  // software mode bypasses the register
  assign out_o = (mode == OM_SW) ? sw_out_i : out_q;

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!flag_o && !scci_o && !out_q));
endmodule

// File: tb/cmp_out_unit_bench.sv
module cmp_out_unit_bench;
  localparam int CNT_W = 16;
  localparam time HALF = 2.5ns;
  localparam int NV = 23;
  localparam logic [CNT_W-1:0] CMP = 16'd10;

  // {mode, cnt, equ0, cci, clr, exp_equ, exp_out, exp_flag, exp_scci}
  localparam logic [25:0] VEC [NV] = '{
    {3'd1, 16'd3,  1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0},
    {3'd1, 16'd10, 1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b1},
    {3'd1, 16'd10, 1'b0,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1},
    {3'd1, 16'd11, 1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b1},
    {3'd5, 16'd10, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0},
    {3'd4, 16'd2,  1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0},
    {3'd4, 16'd10, 1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1},
    {3'd4, 16'd4,  1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1},
    {3'd4, 16'd10, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0},
    {3'd6, 16'd5,  1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b0},
    {3'd2, 16'd10, 1'b0,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b1},
    {3'd6, 16'd9,  1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1},
    {3'd2, 16'd7,  1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1},
    {3'd3, 16'd10, 1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0},
    {3'd3, 16'd0,  1'b1,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0},
    {3'd3, 16'd10, 1'b1,1'b1,1'b0, 1'b1,1'b0,1'b1,1'b1},
    {3'd7, 16'd12, 1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,1'b1},
    {3'd7, 16'd10, 1'b0,1'b0,1'b0, 1'b1,1'b0,1'b1,1'b0},
    {3'd6, 16'd11, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b1,1'b0},
    {3'd6, 16'd10, 1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b1},
    {3'd2, 16'd10, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1},
    {3'd7, 16'd8,  1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b1},
    {3'd7, 16'd10, 1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic [CNT_W-1:0] cmp_val_i = CMP;
  logic             equ0_i = 1'b0;
  logic [2:0]       mode_i = 3'd1;
  logic             sw_out_i = 1'b0;
  logic             cci_i = 1'b0;
  logic             flag_clr_i = 1'b0;
  logic             out_o, equ_o, flag_o, scci_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk_i = ~clk_i;

  cmp_out_unit #(.CNT_W(CNT_W)) u_cmp_out_unit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_i      (cnt_i),
    .cmp_val_i  (cmp_val_i),
    .equ0_i     (equ0_i),
    .mode_i     (mode_i),
    .sw_out_i   (sw_out_i),
    .cci_i      (cci_i),
    .flag_clr_i (flag_clr_i),
    .out_o      (out_o),
    .equ_o      (equ_o),
    .flag_o     (flag_o),
    .scci_o     (scci_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 out", out_o, 1'b0);
    chk("R1 flag", flag_o, 1'b0);
    chk("R1 scci", scci_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      mode_i     = VEC[i][25:23];
      cnt_i      = VEC[i][22:7];
      equ0_i     = VEC[i][6];
      cci_i      = VEC[i][5];
      flag_clr_i = VEC[i][4];
      #1;
      chk($sformatf("R2/R10 equ vec%0d", i), equ_o, VEC[i][3]);
      @(negedge clk_i);
      chk($sformatf("R6/R7/R8/R9 out vec%0d", i), out_o, VEC[i][2]);
      chk($sformatf("R3 flag vec%0d", i), flag_o, VEC[i][1]);
      chk($sformatf("R4 scci vec%0d", i), scci_o, VEC[i][0]);
    end
    equ0_i = 1'b0;
    flag_clr_i = 1'b0;

    // R5 software mode is immediate
    mode_i = 3'd0;
    sw_out_i = 1'b0;
    #1 chk("R5 sw low", out_o, 1'b0);
    sw_out_i = 1'b1;
    #1 chk("R5 sw high", out_o, 1'b1);
    sw_out_i = 1'b0;
    #1 chk("R5 sw low again", out_o, 1'b0);
    @(negedge clk_i);

    // R2 held count: single pulse then quiet
    mode_i = 3'd4;
    cnt_i = 16'd1;
    @(negedge clk_i);
    cnt_i = CMP;
    #1 chk("R2 first reach", equ_o, 1'b1);
    @(negedge clk_i);
    chk("R2 held no pulse", equ_o, 1'b0);
    @(negedge clk_i);
    chk("R2 held still quiet", equ_o, 1'b0);

    // R1 asynchronous reset mid-run
    mode_i = 3'd1;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async out", out_o, 1'b0);
    chk("R1 async flag", flag_o, 1'b0);
    chk("R1 async scci", scci_o, 1'b0);
    @(negedge clk_i);
    finish_run();
  end
endmodule